// File: doc/BRIEF.md
# Chunky Pixel Flood Filter

This block sits in a byte-per-pixel bitmap display path. It takes one colour index per fetched byte and can widen or fill it before the palette sees it. A short list of colour values can then paint whole runs of the screen. The block keeps one remembered colour per scan line and rewrites each incoming index under one of two flood rules. A dedicated marker on the first pixel of a line clears the remembered colour.

Every accepted index leaves the block one cycle later. It can be repeated horizontally up to eight times. While the copies of a pixel are being emitted, the block holds its input ready low, so the fetch side waits. The output has no back-pressure of its own.

Top module: `chunky_flood_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `flood_en` low, the output index equals the accepted input index. The remembered colour is still maintained by the rule that `rule_sel` selects.
- R3: With `flood_en` high and `rule_sel` 0, an input index of 128 to 255 (bit 7 set) is output unchanged and becomes the remembered colour.
- R4: With `flood_en` high and `rule_sel` 0, an input index of 0 to 127 is replaced by the remembered colour when the remembered colour has bit 6 set and the input has bit 6 clear.
- R5: With `rule_sel` 0, any other input index of 0 to 127 is output unchanged and leaves the remembered colour as it was.
- R6: A pixel accepted with `in_sol` high is processed as if the remembered colour were 0, so the remembered colour is cleared at the start of every line.
- R7: With `flood_en` high and `rule_sel` 1, an input of 0 outputs the last non-zero index accepted on the line (0 if there is none). A non-zero input is output unchanged and remembered.
- R8: Each accepted pixel is output for N consecutive cycles, where N is `expand_cnt`+1 when `expand_en` is high and 1 otherwise. `in_ready` is low during the first N-1 of those cycles.
- R9: A pixel accepted at a clock edge appears on `out_valid`/`out_pix` right after that edge. `out_valid` falls after the last copy when no new pixel is accepted.
- R10: The remembered colour changes only on accepted pixels. Inputs presented while `in_ready` is low, including `in_sol`, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input index present |
| in_ready | output | 1 | Block can accept an index this cycle |
| in_pix | input | 8 | Incoming colour index |
| in_sol | input | 1 | Marks the first pixel of a scan line |
| flood_en | input | 1 | Enables the flood rules |
| rule_sel | input | 1 | 0: bit 7 / bit 6 rule, 1: zero-fill rule |
| expand_en | input | 1 | Enables horizontal replication |
| expand_cnt | input | 3 | Extra copies per pixel when enabled |
| out_valid | output | 1 | Output index present |
| out_pix | output | 8 | Output colour index |

## Verification
The bench builds the block with its default 8-bit index and 3-bit expansion field. At that size, every one of the 256 input values can be swept against remembered colours with bit 6 both set and clear, under both rules and with flooding off. It also drives a long pseudo-random stream with random line starts, rule changes and every expansion factor. During stalls it presents different data and line-start markers, which exposes any change of the remembered colour that an unaccepted input might cause.

// File: rtl/cff_pkg.sv
package cff_pkg;
  localparam int PIX_W = 8;
  localparam int TOP_B = PIX_W - 1;
  localparam int FILL_B = PIX_W - 2;
  typedef logic [PIX_W-1:0] pix_t;

  // Output colour under the flood rules, given the effective remembered colour
  function automatic pix_t flood_pick(input pix_t p, input pix_t m, input logic zero_rule);
    if (zero_rule) return (p == '0) ? m : p;
    if (p[TOP_B]) return p;
    if (m[FILL_B] && !p[FILL_B]) return m;
    return p;
  endfunction

  // Next remembered colour after an accepted pixel
  function automatic pix_t keep_next(input pix_t p, input pix_t m, input logic zero_rule);
    if (zero_rule) return (p != '0) ? p : m;
    return p[TOP_B] ? p : m;
  endfunction
endpackage

// File: rtl/cff_colour_mem.sv
module cff_colour_mem
  import cff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic line_start,
  input  logic zero_rule,
  input  pix_t pix,
  output pix_t mem_eff
);
  pix_t mem_q;

  assign mem_eff = line_start ? '0 : mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (accept) mem_q <= keep_next(pix, mem_eff, zero_rule);
  end
endmodule

// File: rtl/cff_rule.sv
module cff_rule
  import cff_pkg::*;
(
  input  logic flood_en,
  input  logic zero_rule,
  input  pix_t pix,
  input  pix_t mem_eff,
  output pix_t pick
);
  assign pick = flood_en ? flood_pick(pix, mem_eff, zero_rule) : pix;
endmodule

// File: rtl/cff_repeat.sv
module cff_repeat
  import cff_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  pix_t             pix_in,
  input  logic             expand_en,
  input  logic [EXP_W-1:0] expand_cnt,
  output logic             busy,
  output logic             out_valid,
  output pix_t             out_pix
);
  logic [EXP_W-1:0] left_q;
  logic [EXP_W-1:0] extra;

  assign extra = expand_en ? expand_cnt : '0;
  assign busy = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (accept) begin
      left_q    <= extra;
      out_valid <= 1'b1;
      out_pix   <= pix_in;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chunky_flood_filter.sv
module chunky_flood_filter
  import cff_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sol,
  input  logic             flood_en,
  input  logic             rule_sel,
  input  logic             expand_en,
  input  logic [EXP_W-1:0] expand_cnt,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic accept;
  logic busy;
  pix_t mem_eff;
  pix_t pick;

  assign in_ready = !busy;
  assign accept = in_valid && in_ready;

  cff_colour_mem u_mem (
    .clk(clk), .rst_n(rst_n), .accept(accept), .line_start(in_sol),
    .zero_rule(rule_sel), .pix(in_pix), .mem_eff(mem_eff)
  );

  cff_rule u_rule (
    .flood_en(flood_en), .zero_rule(rule_sel), .pix(in_pix),
    .mem_eff(mem_eff), .pick(pick)
  );

  cff_repeat #(.EXP_W(EXP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pix_in(pick),
    .expand_en(expand_en), .expand_cnt(expand_cnt), .busy(busy),
    .out_valid(out_valid), .out_pix(out_pix)
  );
endmodule

// File: rtl/cff_chk.sv
module cff_chk
  import cff_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_pix,
  input logic             in_sol,
  input logic             flood_en,
  input logic             rule_sel,
  input logic             expand_en,
  input logic [EXP_W-1:0] expand_cnt,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid && in_ready);
    end
  end

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !flood_en |=> out_pix == $past(in_pix));

  // R3
  high_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && flood_en && !rule_sel && in_pix[TOP_B] |=> out_pix == $past(in_pix));

  // R6
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && flood_en && rule_sel && in_sol && in_pix == '0 |=> out_pix == '0);

  // R7
  nonzero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && flood_en && rule_sel && in_pix != '0 |=> out_pix == $past(in_pix));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid && $stable(out_pix));

  // R8
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (!expand_en || expand_cnt == '0) |=> in_ready);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> !out_valid);
endmodule

bind chunky_flood_filter cff_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pix(in_pix), .in_sol(in_sol), .flood_en(flood_en), .rule_sel(rule_sel),
  .expand_en(expand_en), .expand_cnt(expand_cnt), .out_valid(out_valid),
  .out_pix(out_pix)
);

// File: tb/chunky_flood_filter_tb.sv
module chunky_flood_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_pix = '0;
  logic in_sol = 1'b0;
  logic flood = 1'b0;
  logic rule = 1'b0;
  logic xen = 1'b0;
  logic [2:0] xcnt = '0;
  logic out_valid;
  logic [7:0] out_pix;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] mdl_mem = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  chunky_flood_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sol(in_sol), .flood_en(flood), .rule_sel(rule),
    .expand_en(xen), .expand_cnt(xcnt), .out_valid(out_valid), .out_pix(out_pix)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 8;
  endfunction

  // Applies one pixel at the current negedge and checks all its copies
  task automatic send(input logic [7:0] p, input logic s, input string tag_in);
    logic [7:0] me;
    logic [7:0] ex;
    string t;
    int n;
    me = s ? 8'd0 : mdl_mem;
    if (!flood) begin ex = p; t = "R2"; end
    else if (rule) begin ex = (p == 0) ? me : p; t = "R7"; end
    else if (p >= 128) begin ex = p; t = "R3"; end
    else if ((me / 64) % 2 == 1 && (p / 64) % 2 == 0) begin ex = me; t = "R4"; end
    else begin ex = p; t = "R5"; end
    if (rule) mdl_mem = (p != 0) ? p : me;
    else mdl_mem = (p >= 128) ? p : me;
    if (tag_in != "") t = tag_in;
    n = xen ? int'(xcnt) + 1 : 1;
    in_valid = 1'b1; in_pix = p; in_sol = s;
    chk(in_ready == 1'b1, "R8 ready", int'(in_ready), 1);
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R9 valid", int'(out_valid), 1);
      chk(out_pix == ex, t, int'(out_pix), int'(ex));
      if (k < n - 1) begin
        chk(in_ready == 1'b0, "R8 stall", int'(in_ready), 0);
        // R10: junk during stall must be ignored
        in_valid = 1'b1; in_pix = ~p; in_sol = 1'b1;
      end else begin
        chk(in_ready == 1'b1, "R8 release", int'(in_ready), 1);
        in_valid = 1'b0; in_sol = 1'b0;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drain", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);

    // Sweep every input against seeded remembered colours, both rules, flood on/off
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < 2; r++) begin
        for (int p = 0; p < 256; p++) begin
          flood = f[0]; rule = r[0];
          send(8'((p * 37) % 128 + 128), 1'b1, "");
          send(8'(p), 1'b0, "");
        end
      end
    end
    idle();

    // R6: line start clears a remembered colour with bit 6 set
    flood = 1'b1; rule = 1'b0;
    for (int p = 0; p < 64; p++) begin
      send(8'hC5, 1'b1, "");
      send(8'(p), 1'b1, "R6");
    end
    rule = 1'b1;
    send(8'h33, 1'b0, "");
    send(8'h00, 1'b1, "R6");

    // R10: stalled inputs (different data, line start) leave the colour alone
    for (int x = 1; x < 8; x++) begin
      xen = 1'b1; xcnt = 3'(x);
      send(8'(x * 29 + 1), 1'b0, "");
      xen = 1'b0;
      send(8'h00, 1'b0, "R10");
    end
    idle();

    // Pseudo-random stream over all settings and expansion factors
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      v = rnd();
      flood = (v[3:0] != 0);
      rule = v[4];
      xen = v[5];
      xcnt = v[8:6];
      send((v[9] ? 8'h00 : v[17:10]), (v[22:18] == 0), "");
      if (v[27:23] == 0) idle();
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule